// File: doc/BRIEF.md
# Freeze-on-Error Command Trace Recorder

This block sits in the path of a command word stream that an upstream controller sends to a group of downstream modules. Every word is passed on to the downstream side after one register stage. While passing through, each word is checked against a simple framing rule. While capture is armed, each word is also written into a circular history memory that keeps the most recent words.

When the framing check fails, the offending word is stored as the last history entry and writing stops. The memory then holds the run of traffic that led to the fault. An alert output goes high toward the upstream controller. Software drains the frozen history oldest-first through a read strobe. An arm pulse clears the alert and the pointers and starts a new capture. Forwarding never stops, whatever the capture state.

Top module: `cmd_trace_freeze`

## Requirements
- R1: Each word presented with `in_valid` high appears on `out_valid`/`out_start`/`out_word` exactly one clock later, unchanged, whether capture is running or frozen.
- R2: A word with `in_start`=1 is a header. Its low 4 bits give the number of body words (`in_start`=0) that must follow. A protocol error is a header arriving while body words are still owed, or a body word arriving when none is owed. The owed count is not changed by arm.
- R3: `alert` rises one clock after a valid word that breaks the framing rule, and stays high until an arm pulse.
- R4: While capture runs, each valid word is written as an 17-bit entry {start flag in bit 16, word in bits 15:0} into a 256-entry circular memory. When the memory is full, the oldest entry is overwritten.
- R5: The erroneous word is stored as the final entry. `frozen` rises one clock later. No later word is stored until arm.
- R6: While frozen, each clock with `rd_en` high loads the next entry onto `rd_data`, visible one clock later. The first read returns the oldest of the last 256 entries. Reading continues cyclically, so the 257th read returns the oldest entry again.
- R7: `rd_en` while not frozen has no effect: `rd_data` keeps its value.
- R8: An `arm` pulse clears `alert` and `frozen` and resets both pointers, one clock later. A word that arrives in the same cycle as `arm` is forwarded and checked, but it is not stored and it does not raise the alert.
- R9: After reset, `out_valid`, `alert` and `frozen` are 0, `rd_data` is 0, and capture is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming word strobe |
| in_start | input | 1 | Header flag of incoming word |
| in_word | input | 16 | Incoming command word |
| arm | input | 1 | Clear alert and pointers, restart capture |
| rd_en | input | 1 | Software read strobe |
| out_valid | output | 1 | Forwarded word strobe |
| out_start | output | 1 | Forwarded header flag |
| out_word | output | 16 | Forwarded command word |
| rd_data | output | 17 | History entry read out |
| frozen | output | 1 | Capture halted by an error |
| alert | output | 1 | Transmission error seen |

## Verification
Every result of this block is due one clock after the edge that samples its cause:
- the forwarded word, one clock after the input word;
- `alert` and `frozen`, one clock after the erroneous word;
- a history entry on `rd_data`, one clock after `rd_en`;
- the cleared flags, one clock after `arm`.

The bench changes inputs 2 ns after a rising edge and compares outputs at the following falling edge. A monitor pairs each forwarded word and each read with the oldest item in its expected queue. The expected queues are filled from a circular-memory model and a framing model that the bench keeps from the requirements.

// File: rtl/cmd_trace_pkg.sv
package cmd_trace_pkg;
  typedef enum logic {
    CAP_RUN  = 1'b0,
    CAP_HELD = 1'b1
  } cap_state_e;
endpackage

// File: rtl/trace_fwd_stage.sv
module trace_fwd_stage #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_start,
  input  logic [DATA_W-1:0] in_word,
  output logic              out_valid,
  output logic              out_start,
  output logic [DATA_W-1:0] out_word
);
  logic              vld_q;
  logic              sof_q;
  logic [DATA_W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      sof_q  <= 1'b0;
      word_q <= '0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        sof_q  <= in_start;
        word_q <= in_word;
      end
    end
  end

  assign out_valid = vld_q;
  assign out_start = sof_q;
  assign out_word  = word_q;

  // R1
  fwd_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_valid && out_word == $past(in_word) && out_start == $past(in_start)));
endmodule

// File: rtl/trace_frame_chk.sv
module trace_frame_chk #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic             start,
  input  logic [CNT_W-1:0] cnt_field,
  output logic             err
);
  logic [CNT_W-1:0] owed_q;
  logic [CNT_W-1:0] owed_d;
  logic             err_c;

  always_comb begin
    owed_d = owed_q;
    err_c  = 1'b0;
    if (valid) begin
      if (start) begin
        err_c  = (owed_q != '0);
        owed_d = cnt_field;
      end else begin
        err_c = (owed_q == '0);
        if (owed_q != '0) owed_d = owed_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owed_q <= '0;
    else        owed_q <= owed_d;
  end

  assign err = err_c;

  // R2
  owed_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> $stable(owed_q));
  // R2
  body_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !start && owed_q == '0) |-> err);
endmodule

// File: rtl/trace_store.sv
module trace_store
  import cmd_trace_pkg::*;
#(
  parameter int ENT_W = 17,
  parameter int DEPTH = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             wr_valid,
  input  logic [ENT_W-1:0] wr_entry,
  input  logic             wr_err,
  input  logic             rd_en,
  output logic [ENT_W-1:0] rd_data,
  output logic             frozen,
  output logic             alert
);
  localparam int AW = $clog2(DEPTH);

  logic [ENT_W-1:0] mem [DEPTH];
  cap_state_e       state_q, state_d;
  logic [AW-1:0]    wr_ptr_q, wr_ptr_d;
  logic [AW-1:0]    rd_ptr_q, rd_ptr_d;
  logic [ENT_W-1:0] rd_data_q, rd_data_d;
  logic             alert_q, alert_d;
  logic             cap_write;
  logic             rd_fire;

  assign cap_write = (state_q == CAP_RUN) && wr_valid && !arm;
  assign rd_fire   = (state_q == CAP_HELD) && rd_en && !arm;

  always_comb begin
    state_d   = state_q;
    wr_ptr_d  = wr_ptr_q;
    rd_ptr_d  = rd_ptr_q;
    rd_data_d = rd_data_q;
    alert_d   = alert_q;
    if (arm) begin
      state_d  = CAP_RUN;
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      alert_d  = 1'b0;
    end else begin
      if (wr_valid && wr_err) alert_d = 1'b1;
      if (cap_write) begin
        wr_ptr_d = wr_ptr_q + 1'b1;
        rd_ptr_d = wr_ptr_q + 1'b1;
        if (wr_err) state_d = CAP_HELD;
      end else if (rd_fire) begin
        rd_ptr_d  = rd_ptr_q + 1'b1;
        rd_data_d = mem[rd_ptr_q];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (cap_write) mem[wr_ptr_q] <= wr_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= CAP_RUN;
      wr_ptr_q  <= '0;
      rd_ptr_q  <= '0;
      rd_data_q <= '0;
      alert_q   <= 1'b0;
    end else begin
      state_q   <= state_d;
      wr_ptr_q  <= wr_ptr_d;
      rd_ptr_q  <= rd_ptr_d;
      rd_data_q <= rd_data_d;
      alert_q   <= alert_d;
    end
  end

  assign rd_data = rd_data_q;
  assign frozen  = (state_q == CAP_HELD);
  assign alert   = alert_q;

  // R3
  alert_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alert_q && !arm) |=> alert_q);
  // R5
  held_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !arm) |=> (frozen && $stable(wr_ptr_q)));
  // R7
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frozen |=> $stable(rd_data_q));
  // R8
  arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (!alert_q && !frozen && wr_ptr_q == '0));
endmodule

// File: rtl/cmd_trace_freeze.sv
module cmd_trace_freeze #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 256,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_start,
  input  logic [DATA_W-1:0] in_word,
  input  logic              arm,
  input  logic              rd_en,
  output logic              out_valid,
  output logic              out_start,
  output logic [DATA_W-1:0] out_word,
  output logic [DATA_W:0]   rd_data,
  output logic              frozen,
  output logic              alert
);
  localparam int ENT_W = DATA_W + 1;

  logic frame_err;

  trace_fwd_stage #(.DATA_W(DATA_W)) u_fwd (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_start  (in_start),
    .in_word   (in_word),
    .out_valid (out_valid),
    .out_start (out_start),
    .out_word  (out_word)
  );

  trace_frame_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid     (in_valid),
    .start     (in_start),
    .cnt_field (in_word[CNT_W-1:0]),
    .err       (frame_err)
  );

  trace_store #(.ENT_W(ENT_W), .DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (arm),
    .wr_valid (in_valid),
    .wr_entry ({in_start, in_word}),
    .wr_err   (frame_err),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .frozen   (frozen),
    .alert    (alert)
  );

  // R3
  err_alert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && frame_err && !arm) |=> alert);
  // R5
  err_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && frame_err && !arm) |=> frozen);
endmodule

// File: tb/cmd_trace_freeze_test.sv
module cmd_trace_freeze_test;
  localparam int DW = 16;
  localparam int DEPTH = 256;
  localparam int CW = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, in_valid, in_start, arm, rd_en;
  logic [DW-1:0] in_word;
  logic out_valid, out_start, frozen, alert;
  logic [DW-1:0] out_word;
  logic [DW:0] rd_data;

  cmd_trace_freeze uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
    .in_word(in_word), .arm(arm), .rd_en(rd_en), .out_valid(out_valid),
    .out_start(out_start), .out_word(out_word), .rd_data(rd_data),
    .frozen(frozen), .alert(alert)
  );

  int checks = 0;
  int errors = 0;
  logic [DW:0] fwd_q[$];
  logic [DW:0] rd_q[$];
  logic [DW:0] mem_m [DEPTH];
  int wp_m = 0;
  int rdp_m = 0;
  int rem_m = 0;
  bit frozen_m = 0;
  logic rd_pend;
  bit done = 0;

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(bit s, logic [DW-1:0] w, bit with_arm = 1'b0);
    bit e;
    @(posedge clk); #2;
    in_valid = 1'b1; in_start = s; in_word = w; arm = with_arm; rd_en = 1'b0;
    if (s) begin e = (rem_m != 0); rem_m = int'(w[CW-1:0]); end
    else begin e = (rem_m == 0); if (rem_m != 0) rem_m--; end
    fwd_q.push_back({s, w});
    if (with_arm) begin
      wp_m = 0; frozen_m = 0;
    end else if (!frozen_m) begin
      mem_m[wp_m] = {s, w};
      wp_m = (wp_m + 1) % DEPTH;
      if (e) frozen_m = 1;
    end
  endtask

  task automatic idle();
    @(posedge clk); #2;
    in_valid = 1'b0; arm = 1'b0; rd_en = 1'b0;
  endtask

  task automatic read_n(int n, bit expect_data);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      in_valid = 1'b0; arm = 1'b0; rd_en = 1'b1;
      if (expect_data) begin
        rd_q.push_back(mem_m[rdp_m]);
        rdp_m = (rdp_m + 1) % DEPTH;
      end
    end
    idle();
  endtask

  always @(posedge clk) rd_pend <= rd_en;

  // monitor: compare outputs against the expected queues
  initial begin
    logic [DW:0] e;
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1) begin
        if (out_valid === 1'b1) begin
          if (fwd_q.size() == 0) chk(1'b0, "R1 unexpected word", longint'({out_start, out_word}), 0);
          else begin
            e = fwd_q.pop_front();
            chk({out_start, out_word} === e, "R1 forwarded word", longint'({out_start, out_word}), longint'(e));
          end
        end
        if (rd_pend === 1'b1 && rd_q.size() > 0) begin
          e = rd_q.pop_front();
          chk(rd_data === e, "R6 R4 R5 history entry", longint'(rd_data), longint'(e));
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_start = 1'b0; in_word = '0; arm = 1'b0; rd_en = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(out_valid == 1'b0, "R9 out_valid", longint'(out_valid), 0);
    chk(alert == 1'b0, "R9 alert", longint'(alert), 0);
    chk(frozen == 1'b0, "R9 frozen", longint'(frozen), 0);
    chk(rd_data == '0, "R9 rd_data", longint'(rd_data), 0);

    // well-formed traffic, more than DEPTH words (R4 wrap, R2 no false error)
    for (int c = 0; c < 130; c++) begin
      automatic logic [3:0] len = 4'(c % 4);
      send(1'b1, {12'(c), len});
      for (int j = 0; j < int'(len); j++) send(1'b0, 16'(c * 7 + j + 16'h100));
    end
    idle();
    @(negedge clk);
    chk(alert == 1'b0, "R2 R3 no alert on clean framing", longint'(alert), 0);
    chk(frozen == 1'b0, "R2 R5 not frozen on clean framing", longint'(frozen), 0);

    // R7 reads while running are ignored
    read_n(3, 1'b0);
    @(negedge clk);
    chk(rd_data == '0, "R7 rd_data unchanged while running", longint'(rd_data), 0);

    // R2 body word with nothing owed -> error
    send(1'b0, 16'hDEAD);
    idle();
    chk(alert == 1'b1, "R3 alert after error", longint'(alert), 1);
    chk(frozen == 1'b1, "R5 frozen after error", longint'(frozen), 1);
    // more traffic: forwarded (R1) but not stored (R5)
    send(1'b1, 16'h0000);
    send(1'b1, 16'h0010);
    idle();
    @(negedge clk);
    chk(frozen == 1'b1, "R5 still frozen", longint'(frozen), 1);
    chk(alert == 1'b1, "R3 alert held", longint'(alert), 1);

    // R6 read out oldest-first, one wrap past the end
    rdp_m = wp_m;
    read_n(DEPTH + 1, 1'b1);

    // R8 owed count survives arm; word with arm is not stored
    send(1'b1, 16'h0002);
    send(1'b0, 16'h0001);
    send(1'b0, 16'h0002, 1'b1);
    idle();
    chk(alert == 1'b0, "R8 alert cleared", longint'(alert), 0);
    chk(frozen == 1'b0, "R8 frozen cleared", longint'(frozen), 0);

    // R2 header while body owed -> error
    send(1'b1, 16'h0003);
    send(1'b0, 16'h0005);
    send(1'b1, 16'h0000);
    idle();
    chk(alert == 1'b1, "R2 R3 alert on early header", longint'(alert), 1);
    chk(frozen == 1'b1, "R2 R5 frozen on early header", longint'(frozen), 1);
    rdp_m = wp_m;
    read_n(DEPTH, 1'b1);
    repeat (3) @(negedge clk);
    chk(fwd_q.size() == 0, "R1 all words forwarded", longint'(fwd_q.size()), 0);
    chk(rd_q.size() == 0, "R6 all reads returned", longint'(rd_q.size()), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule